// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block guards a shared bus against cycles that never finish. It watches an active-low cycle strobe. While the strobe is held it counts clocks. Once the count reaches the limit picked by a two-bit active-low period code, it drives an active-low bus error and stays there until the strobe is released. One code value switches the limit off completely.

When the error is first raised, the block sets a sticky timeout flag. In the same clock it latches the two active-low acknowledge/size lines, which record how the addressed slave answered. A separate sticky flag records pulses that report a write attempted on a read-only bus. A clear pulse returns every status bit to its reset value.

The limits are computed from a clock-frequency parameter, given in kHz. The default of 16670 kHz gives 1067, 2134 and 4268 clocks for 64, 128 and 256 us, with each value rounded to the nearest clock. All pins are plain level or pulse signals, so there is no stream handshake.

Top module: `cto_monitor_top`

## Requirements
- R1: While reset is asserted and after it is released, err_n is 1, stat_timeout is 0, stat_wr_viol is 0 and stat_size_n is 2'b11.
- R2: The count advances only on clocks where strobe_n is sampled 0. One clock with strobe_n sampled 1 restarts it from zero, so two holds that are each one clock short of the limit raise no error.
- R3: err_n goes to 0 on the clock edge that completes LIMIT consecutive clocks with strobe_n sampled 0, and not one edge earlier.
- R4: per_sel_n[1:0] selects LIMIT: 2'b00 gives 1067 clocks (64 us), 2'b01 gives 2134 (128 us), 2'b10 gives 4268 (256 us) and 2'b11 gives no limit. All values are for the default 16670 kHz.
- R5: With per_sel_n = 2'b11, err_n never falls, however long the strobe is held.
- R6: Once low, err_n stays 0 while strobe_n is sampled 0. It returns to 1 on the first edge that samples strobe_n as 1.
- R7: On the edge where err_n falls, stat_timeout becomes 1 and stat_size_n takes size_ack_n. The codes are 2'b11 for no response, 2'b10 for an 8-bit slave, 2'b01 for a 16-bit slave and 2'b00 for a 32-bit slave. Later changes on size_ack_n do not alter stat_size_n.
- R8: A clock with wr_viol = 1 sets stat_wr_viol, which stays 1.
- R9: The status bits change only on reset, on a set event or on a clr_stat pulse. clr_stat returns them to their R1 values. A set event on the same edge as clr_stat wins.
- R10: A change of per_sel_n during a held strobe is compared at once against the current count. If the count already exceeds the new limit, err_n falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Active-low bus cycle strobe |
| per_sel_n | input | 2 | Active-low timeout period code |
| size_ack_n | input | 2 | Active-low acknowledge/size lines |
| wr_viol | input | 1 | Pulse: write attempted on a read-only bus |
| clr_stat | input | 1 | Pulse: return status bits to reset values |
| err_n | output | 1 | Active-low bus error |
| stat_timeout | output | 1 | Sticky timeout flag |
| stat_wr_viol | output | 1 | Sticky write-violation flag |
| stat_size_n | output | 2 | Size code latched at the last timeout |

## Verification
Two functions can land on the same clock edge. One is the clear pulse. The other is a status set, from either a timeout just expiring or a write-violation pulse. The bench provokes this in two ways. It fires clr_stat on exactly the edge where a held strobe reaches its limit. It also fires clr_stat together with wr_viol, and again in random traffic where both pulses are drawn independently. In every case the set must survive the clear, and a bench model that applies sets after clears judges the result.

// File: rtl/cto_pkg.sv
package cto_pkg;

  typedef enum logic [1:0] {
    PER_SHORT = 2'b00,
    PER_MID   = 2'b01,
    PER_LONG  = 2'b10,
    PER_NONE  = 2'b11
  } per_code_e;

  localparam logic [1:0] SIZE_NONE = 2'b11;

  function automatic int cycles_for_us(input int clk_khz, input int us);
    return (clk_khz * us + 500) / 1000;
  endfunction

endpackage

// File: rtl/cto_limit_dec.sv
module cto_limit_dec
  import cto_pkg::*;
#(
  parameter int CW      = 13,
  parameter int LIM_S   = 1067,
  parameter int LIM_M   = 2134,
  parameter int LIM_L   = 4268
) (
  input  logic [1:0]    per_sel_n,
  output logic [CW-1:0] limit,
  output logic          no_limit
);

  always_comb begin
    no_limit = 1'b0;
    case (per_code_e'(per_sel_n))
      PER_SHORT: limit = CW'(LIM_S);
      PER_MID:   limit = CW'(LIM_M);
      PER_LONG:  limit = CW'(LIM_L);
      default: begin
        limit    = '1;
        no_limit = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cto_cycle_cnt.sv
module cto_cycle_cnt #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic [CW-1:0] limit,
  input  logic          no_limit,
  output logic          err_q,
  output logic          err_rise
);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_plus;
  logic          held;
  logic          expire;

  assign held     = ~strobe_n;
  assign cnt_plus = {1'b0, cnt_q} + 1'b1;
  // expiry uses the limit presented this cycle, so a period change acts at once
  assign expire   = held & ~no_limit & (cnt_plus >= {1'b0, limit});
  assign err_rise = expire & ~err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (!held)
        cnt_q <= '0;
      else if (cnt_q != '1)
        cnt_q <= cnt_plus[CW-1:0];
      err_q <= held & (err_q | expire);
    end
  end

endmodule

// File: rtl/cto_status_reg.sv
module cto_status_reg
  import cto_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_rise,
  input  logic [1:0] size_ack_n,
  input  logic       wr_viol,
  input  logic       clr_stat,
  output logic       stat_timeout,
  output logic       stat_wr_viol,
  output logic [1:0] stat_size_n
);

  // set events are applied after the clear so they win on a shared edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_timeout <= 1'b0;
      stat_wr_viol <= 1'b0;
      stat_size_n  <= SIZE_NONE;
    end else begin
      if (clr_stat) begin
        stat_timeout <= 1'b0;
        stat_wr_viol <= 1'b0;
        stat_size_n  <= SIZE_NONE;
      end
      if (err_rise) begin
        stat_timeout <= 1'b1;
        stat_size_n  <= size_ack_n;
      end
      if (wr_viol)
        stat_wr_viol <= 1'b1;
    end
  end

endmodule

// File: rtl/cto_monitor_top.sv
module cto_monitor_top
  import cto_pkg::*;
#(
  parameter int CLK_KHZ  = 16670,
  parameter int US_SHORT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_n,
  input  logic [1:0] per_sel_n,
  input  logic [1:0] size_ack_n,
  input  logic       wr_viol,
  input  logic       clr_stat,
  output logic       err_n,
  output logic       stat_timeout,
  output logic       stat_wr_viol,
  output logic [1:0] stat_size_n
);

  localparam int LIM_S = cycles_for_us(CLK_KHZ, US_SHORT);
  localparam int LIM_M = cycles_for_us(CLK_KHZ, 2 * US_SHORT);
  localparam int LIM_L = cycles_for_us(CLK_KHZ, 4 * US_SHORT);
  localparam int CW    = $clog2(LIM_L + 1) + 1;

  logic [CW-1:0] limit;
  logic          no_limit;
  logic          err_q;
  logic          err_rise;

  cto_limit_dec #(
    .CW(CW), .LIM_S(LIM_S), .LIM_M(LIM_M), .LIM_L(LIM_L)
  ) u_dec (
    .per_sel_n (per_sel_n),
    .limit     (limit),
    .no_limit  (no_limit)
  );

  cto_cycle_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (strobe_n),
    .limit    (limit),
    .no_limit (no_limit),
    .err_q    (err_q),
    .err_rise (err_rise)
  );

  cto_status_reg u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_rise     (err_rise),
    .size_ack_n   (size_ack_n),
    .wr_viol      (wr_viol),
    .clr_stat     (clr_stat),
    .stat_timeout (stat_timeout),
    .stat_wr_viol (stat_wr_viol),
    .stat_size_n  (stat_size_n)
  );

  assign err_n = ~err_q;

endmodule

// File: rtl/cto_monitor_chk.sv
module cto_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe_n,
  input logic [1:0] per_sel_n,
  input logic       wr_viol,
  input logic       clr_stat,
  input logic       err_n,
  input logic       stat_timeout,
  input logic       stat_wr_viol,
  input logic [1:0] stat_size_n
);

  a_r6_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_n && !strobe_n) |=> !err_n);

  a_r6_err_release: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |=> err_n);

  a_r3_err_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> $past(!strobe_n));

  a_r5_no_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel_n == 2'b11 && err_n) |=> err_n);

  a_r8_wr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol |=> stat_wr_viol);

  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_timeout && !clr_stat) |=> stat_timeout);

  a_r7_size_held: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stat |=> ($stable(stat_size_n) || $fell(err_n)));

  a_r7_timeout_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> stat_timeout);

endmodule

bind cto_monitor_top cto_monitor_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strobe_n     (strobe_n),
  .per_sel_n    (per_sel_n),
  .wr_viol      (wr_viol),
  .clr_stat     (clr_stat),
  .err_n        (err_n),
  .stat_timeout (stat_timeout),
  .stat_wr_viol (stat_wr_viol),
  .stat_size_n  (stat_size_n)
);

// File: tb/cto_monitor_top_tb_top.sv
`timescale 1ns/1ps
module cto_monitor_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe_n;
  logic [1:0] per_sel_n;
  logic [1:0] size_ack_n;
  logic       wr_viol;
  logic       clr_stat;
  logic       err_n;
  logic       stat_timeout;
  logic       stat_wr_viol;
  logic [1:0] stat_size_n;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model state
  int       m_cnt;
  bit       m_err;
  bit       m_to;
  bit       m_wr;
  bit [1:0] m_size;

  always #10 clk = ~clk;

  cto_monitor_top dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .per_sel_n(per_sel_n),
    .size_ack_n(size_ack_n), .wr_viol(wr_viol), .clr_stat(clr_stat),
    .err_n(err_n), .stat_timeout(stat_timeout), .stat_wr_viol(stat_wr_viol),
    .stat_size_n(stat_size_n)
  );

  function automatic int lim_of(input bit [1:0] sel);
    case (sel)
      2'b00:   return 1067;
      2'b01:   return 2134;
      2'b10:   return 4268;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int  lim;
    bit  held, exp_now, rise;
    lim     = lim_of(per_sel_n);
    held    = !strobe_n;
    exp_now = held && (lim > 0) && (m_cnt + 1 >= lim);
    rise    = exp_now && !m_err;
    m_err   = held && (m_err || exp_now);
    m_cnt   = held ? m_cnt + 1 : 0;
    if (clr_stat) begin m_to = 0; m_wr = 0; m_size = 2'b11; end
    if (rise) begin m_to = 1; m_size = size_ack_n; end
    if (wr_viol) m_wr = 1;
  endtask

  task automatic compare(input string tag);
    chk({tag, " err_n"}, err_n, !m_err);
    chk({tag, " timeout"}, stat_timeout, m_to);
    chk({tag, " wr"}, stat_wr_viol, m_wr);
    chk({tag, " size"}, stat_size_n, m_size);
  endtask

  // one clock: inputs applied at negedge, result compared at next negedge
  task automatic cyc(input bit s, input bit [1:0] sel, input bit [1:0] sz,
                     input bit w, input bit c, input string tag);
    strobe_n = s; per_sel_n = sel; size_ack_n = sz; wr_viol = w; clr_stat = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic hold(input int n, input bit [1:0] sel, input bit [1:0] sz, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, sel, sz, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b1, 2'b00, 2'b11, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; strobe_n = 1'b1; per_sel_n = 2'b00; size_ack_n = 2'b11;
    wr_viol = 1'b0; clr_stat = 1'b0;
    m_cnt = 0; m_err = 0; m_to = 0; m_wr = 0; m_size = 2'b11;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    idle("R1 after reset");

    // R2: two holds each one short of the limit
    hold(1066, 2'b00, 2'b10, "R2");
    idle("R2");
    hold(1066, 2'b00, 2'b10, "R2");
    chk("R2 no error after split holds", err_n, 1);
    idle("R2");

    // R3 / R7: exact expiry edge and size capture
    hold(1066, 2'b00, 2'b10, "R3");
    chk("R3 not one edge early", err_n, 1);
    hold(1, 2'b00, 2'b10, "R3");
    chk("R3 err at limit", err_n, 0);
    chk("R7 timeout set", stat_timeout, 1);
    chk("R7 size 8-bit captured", stat_size_n, 2'b10);
    hold(20, 2'b00, 2'b00, "R7");
    chk("R7 size unchanged later", stat_size_n, 2'b10);
    chk("R6 err held", err_n, 0);
    idle("R6");
    chk("R6 err released", err_n, 1);

    // R9: clear, and clear coinciding with expiry
    cyc(1'b1, 2'b00, 2'b11, 1'b0, 1'b1, "R9");
    chk("R9 clear timeout", stat_timeout, 0);
    chk("R9 clear size", stat_size_n, 2'b11);
    hold(1066, 2'b00, 2'b01, "R9");
    cyc(1'b0, 2'b00, 2'b01, 1'b0, 1'b1, "R9");
    chk("R9 set wins over clear", stat_timeout, 1);
    chk("R9 size on shared edge", stat_size_n, 2'b01);
    idle("R9");

    // R4: the other two limits
    hold(2133, 2'b01, 2'b00, "R4");
    chk("R4 mid not early", err_n, 1);
    hold(1, 2'b01, 2'b00, "R4");
    chk("R4 mid limit", err_n, 0);
    idle("R4");
    hold(4267, 2'b10, 2'b11, "R4");
    chk("R4 long not early", err_n, 1);
    hold(1, 2'b10, 2'b11, "R4");
    chk("R4 long limit", err_n, 0);
    idle("R4");

    // R5: no limit
    hold(5000, 2'b11, 2'b00, "R5");
    chk("R5 never errors", err_n, 1);

    // R10: switch to short limit with count already past it
    cyc(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, "R10");
    chk("R10 immediate expiry", err_n, 0);
    chk("R10 size 32-bit", stat_size_n, 2'b00);
    idle("R10");

    // R8: write violation, and with clear on the same edge
    cyc(1'b1, 2'b00, 2'b11, 1'b1, 1'b0, "R8");
    chk("R8 wr set", stat_wr_viol, 1);
    idle("R8");
    chk("R8 wr sticky", stat_wr_viol, 1);
    cyc(1'b1, 2'b00, 2'b11, 1'b1, 1'b1, "R9");
    chk("R9 wr wins over clear", stat_wr_viol, 1);
    cyc(1'b1, 2'b00, 2'b11, 1'b0, 1'b1, "R9");
    chk("R9 wr cleared", stat_wr_viol, 0);

    // random bursts
    for (int b = 0; b < 14; b++) begin
      int len;
      bit [1:0] sel;
      len = $urandom_range(2300, 0);
      sel = 2'($urandom_range(3, 0));
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(300, 0) == 0) sel = 2'($urandom_range(3, 0));
        cyc(1'b0, sel, 2'($urandom_range(3, 0)),
            $urandom_range(49, 0) == 0, $urandom_range(59, 0) == 0, "R2 R3 R9 random");
      end
      for (int i = 0; i < int'($urandom_range(3, 1)); i++)
        cyc(1'b1, sel, 2'($urandom_range(3, 0)),
            $urandom_range(9, 0) == 0, $urandom_range(9, 0) == 0, "R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule